// File: doc/BRIEF.md
# Edge-Triggered Set/Clear Phase Detector

This block measures the phase offset between a reference square wave and a feedback square wave. It is meant for a clock-recovery loop that runs all of its logic from a fast system clock. Each input is brought into the system clock domain through a synchronizer, and a one-cycle pulse is formed on each of its rising edges. A single output bit is driven high by reference edges and low by feedback edges. If both edges arrive in the same cycle, the bit flips. The bit therefore behaves like a J-K flip-flop with J tied to the reference and K tied to the feedback.

A windowed averager counts how many system clocks the output bit spends high over a window of 2^WIN_LOG2 cycles. It reports that count with a one-cycle strobe. The count rises linearly with phase offset across a full 2π: mid-scale (the nominal lock point) means the inputs are 180° apart, and full scale means 2π. Only rising edges enter the computation, so input duty cycle has no effect. Because only edges matter, an input running at a harmonic of the other can produce the same count as an equal-frequency pair.

Top module: `edge_phase_det`

## Requirements
- R1: A reference rising edge with no feedback rising edge in the same detected cycle drives `phase_out` high. The input is sampled on a clock edge, and `phase_out` changes on the second clock edge after that sampling edge.
- R2: A feedback rising edge with no reference rising edge in the same detected cycle drives `phase_out` low, with the same latency as R1.
- R3: When a reference and a feedback rising edge are detected in the same cycle, `phase_out` inverts.
- R4: Falling edges and input levels have no effect on `phase_out`. Changing the duty cycle of either input while keeping its rising edges fixed leaves the window count unchanged.
- R5: While `rst` is high and on the first cycle after it, `phase_out` is 0, `avg_valid` is 0 and `avg_count` is 0.
- R6: `avg_valid` is a single-cycle pulse that repeats every 2^WIN_LOG2 cycles. The first pulse follows the 2^WIN_LOG2-th clock edge after reset is released.
- R7: When `avg_valid` is 1, `avg_count` equals the number of cycles in the window just ended during which `phase_out` was 1. `avg_count` holds that value until the next pulse.
- R8: Equal-frequency inputs that are 180° apart give a count of exactly 2^(WIN_LOG2-1), which is mid-scale.
- R9: Reference edges with no feedback edges hold `phase_out` high, which gives the full-scale count of 2^WIN_LOG2 (a 2π offset).
- R10: A feedback input at twice the reference frequency, offset by d cycles, gives the same count as an equal-frequency feedback input with the same offset d.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk_in | input | 1 | Reference square wave, asynchronous to clk |
| fb_clk_in | input | 1 | Feedback square wave, asynchronous to clk |
| phase_out | output | 1 | Set/clear phase bit |
| avg_count | output | WIN_LOG2+1 | High-cycle count of the last finished window |
| avg_valid | output | 1 | One-cycle strobe marking a new avg_count |

## Verification
The inputs change half a cycle before a clock edge. Counting that edge as the first, `phase_out` reflects a resulting edge after the third edge: two synchronizer stages plus the output register. The count and strobe for a window appear one edge after the window's last cycle. A behavioural model in the bench keeps a short queue of sampled inputs and applies these delays. It compares every output at each falling clock edge, so each result is checked in exactly the cycle it becomes due. The scenario checks on mid-scale, full scale, duty cycle and harmonic equality read the last reported count. They read it only after several complete windows, so the window being read is in steady state.

// File: rtl/phase_det_pkg.sv
package phase_det_pkg;

    typedef struct packed {
        logic ref_rise;
        logic fb_rise;
    } edge_pair_t;

    typedef enum logic [1:0] {
        EV_HOLD   = 2'd0,
        EV_SET    = 2'd1,
        EV_CLEAR  = 2'd2,
        EV_TOGGLE = 2'd3
    } pd_event_e;

    function automatic pd_event_e classify(input edge_pair_t e);
        case ({e.ref_rise, e.fb_rise})
            2'b10:   return EV_SET;
            2'b01:   return EV_CLEAR;
            2'b11:   return EV_TOGGLE;
            default: return EV_HOLD;
        endcase
    endfunction

    function automatic logic apply_event(input pd_event_e ev, input logic cur);
        case (ev)
            EV_SET:    return 1'b1;
            EV_CLEAR:  return 1'b0;
            EV_TOGGLE: return ~cur;
            default:   return cur;
        endcase
    endfunction

endpackage

// File: rtl/pd_sync_edge.sv
module pd_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= {shreg[STAGES-1:0], async_in};
    end

    assign rise = shreg[STAGES-1] & ~shreg[STAGES];

    // R1
    rise_single_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/pd_setclr.sv
module pd_setclr
    import phase_det_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  edge_pair_t edges,
    output logic       q
);
    pd_event_e ev;

    assign ev = classify(edges);

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= apply_event(ev, q);
    end

    // R1
    set_on_ref_chk: assert property (@(posedge clk) disable iff (rst)
        (edges.ref_rise && !edges.fb_rise) |=> q);
    // R2
    clear_on_fb_chk: assert property (@(posedge clk) disable iff (rst)
        (edges.fb_rise && !edges.ref_rise) |=> !q);
    // R3
    toggle_both_chk: assert property (@(posedge clk) disable iff (rst)
        (edges.fb_rise && edges.ref_rise) |=> (q != $past(q)));
    // R4
    hold_no_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (!edges.fb_rise && !edges.ref_rise) |=> $stable(q));

endmodule

// File: rtl/pd_window_avg.sv
module pd_window_avg #(
    parameter int WIN_LOG2 = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              level,
    output logic [WIN_LOG2:0] count,
    output logic              valid
);
    localparam logic [WIN_LOG2-1:0] LAST_POS = '1;
    localparam logic [WIN_LOG2:0]   FULL     = (WIN_LOG2+1)'(1) << WIN_LOG2;

    logic [WIN_LOG2-1:0] pos;
    logic [WIN_LOG2:0]   acc;
    logic [WIN_LOG2:0]   acc_next;

    assign acc_next = acc + (WIN_LOG2+1)'(level);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos   <= '0;
            acc   <= '0;
            count <= '0;
            valid <= 1'b0;
        end else begin
            pos <= pos + 1'b1;
            if (pos == LAST_POS) begin
                count <= acc_next;
                acc   <= '0;
                valid <= 1'b1;
            end else begin
                acc   <= acc_next;
                valid <= 1'b0;
            end
        end
    end

    // R6
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);
    // R7
    count_range_chk: assert property (@(posedge clk) disable iff (rst)
        valid |-> (count <= FULL));
    // R7
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid |=> (valid || $stable(count)));

endmodule

// File: rtl/edge_phase_det.sv
module edge_phase_det
    import phase_det_pkg::*;
#(
    parameter int WIN_LOG2    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_clk_in,
    input  logic              fb_clk_in,
    output logic              phase_out,
    output logic [WIN_LOG2:0] avg_count,
    output logic              avg_valid
);
    edge_pair_t edges;

    pd_sync_edge #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (ref_clk_in),
        .rise     (edges.ref_rise)
    );

    pd_sync_edge #(.STAGES(SYNC_STAGES)) u_fb_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (fb_clk_in),
        .rise     (edges.fb_rise)
    );

    pd_setclr u_core (
        .clk   (clk),
        .rst   (rst),
        .edges (edges),
        .q     (phase_out)
    );

    pd_window_avg #(.WIN_LOG2(WIN_LOG2)) u_avg (
        .clk   (clk),
        .rst   (rst),
        .level (phase_out),
        .count (avg_count),
        .valid (avg_valid)
    );

    // R5
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!phase_out && !avg_valid && avg_count == '0));

endmodule

// File: tb/edge_phase_det_bench.sv
module edge_phase_det_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int W  = 1 << N;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0;
    logic fb_in = 1'b0;
    logic phase_out;
    logic [N:0] avg_count;
    logic avg_valid;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    edge_phase_det #(.WIN_LOG2(N), .SYNC_STAGES(2)) u_edge_phase_det (
        .clk(clk), .rst(rst), .ref_clk_in(ref_in), .fb_clk_in(fb_in),
        .phase_out(phase_out), .avg_count(avg_count), .avg_valid(avg_valid)
    );

    // behavioural model
    bit ref_q[$];
    bit fb_q[$];
    bit m_q = 0;
    bit m_valid = 0;
    int m_cnt = 0;
    int m_pos = 0;
    int m_acc = 0;
    string m_tag = "R4";
    bit m_in_rst = 1;

    always @(posedge clk) begin
        if (rst) begin
            ref_q = '{0, 0, 0, 0};
            fb_q  = '{0, 0, 0, 0};
            m_q = 0; m_valid = 0; m_cnt = 0; m_pos = 0; m_acc = 0;
            m_tag = "R5"; m_in_rst = 1;
        end else begin
            bit rr, fr;
            ref_q.push_front(ref_in);
            fb_q.push_front(fb_in);
            rr = ref_q[2] && !ref_q[3];
            fr = fb_q[2] && !fb_q[3];
            void'(ref_q.pop_back());
            void'(fb_q.pop_back());
            if (m_pos == W - 1) begin
                m_cnt = m_acc + int'(m_q);
                m_acc = 0; m_pos = 0; m_valid = 1;
            end else begin
                m_acc = m_acc + int'(m_q);
                m_pos = m_pos + 1; m_valid = 0;
            end
            if (rr && fr)      begin m_q = !m_q; m_tag = "R3"; end
            else if (rr)       begin m_q = 1;    m_tag = "R1"; end
            else if (fr)       begin m_q = 0;    m_tag = "R2"; end
            else               m_tag = "R4";
            m_in_rst = 0;
        end
    end

    int last_cnt = -1;

    always @(negedge clk) begin
        if (!done) begin
            vectors++;
            if (phase_out !== m_q) begin
                fails++;
                $display("FAIL %s phase_out: actual %0b expected %0b", m_tag, phase_out, m_q);
            end
            vectors++;
            if (avg_valid !== m_valid) begin
                fails++;
                $display("FAIL R6 avg_valid: actual %0b expected %0b", avg_valid, m_valid);
            end
            vectors++;
            if (int'(avg_count) != m_cnt) begin
                fails++;
                $display("FAIL %s avg_count: actual %0d expected %0d",
                         m_in_rst ? "R5" : "R7", avg_count, m_cnt);
            end
            if (avg_valid) last_cnt = int'(avg_count);
        end
    end

    task automatic check_val(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run_scn(int rper, int rhi, int fper, int fhi, int foff, int cycles);
        for (int t = 0; t < cycles; t++) begin
            @(negedge clk);
            ref_in = (t % rper) < rhi;
            fb_in  = ((t + fper * 1000 - foff) % fper) < fhi;
        end
    endtask

    int cnt_equal;

    initial begin
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R5 checked by the per-cycle model during and just after reset
        // R8: 180 degrees apart, equal frequency
        run_scn(32, 16, 32, 16, 16, 4 * W);
        check_val("R8 mid-scale count", last_cnt, W / 2);
        // R4: different duty cycles, same rising edges
        run_scn(32, 4, 32, 28, 16, 4 * W);
        check_val("R4 duty-cycle independence", last_cnt, W / 2);
        // R3: coincident edges toggle the output
        run_scn(32, 16, 32, 16, 0, 4 * W);
        check_val("R3 coincident-edge toggle count", last_cnt, W / 2);
        // R9: no feedback edges -> full scale
        run_scn(32, 16, 32, 0, 0, 4 * W);
        check_val("R9 full-scale count", last_cnt, W);
        // R10: harmonic vs equal frequency at the same offset
        run_scn(64, 32, 64, 32, 8, 4 * W);
        cnt_equal = last_cnt;
        check_val("R10 equal-frequency count", cnt_equal, W / 8);
        run_scn(64, 32, 32, 16, 8, 4 * W);
        check_val("R10 harmonic count matches", last_cnt, cnt_equal);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule